// File: doc/BRIEF.md
# Serial ADC Conversion Read Controller

This block sits on the host side of a 14-bit serial analog-to-digital converter. It drives the converter's active-low conversion-start line and its serial clock, and it watches the converter's busy line and serial data line. A conversion can be started by a one-cycle software request or by an internal periodic trigger. The controller shapes the conversion-start pulse, waits for busy to drop, clocks out a 16-bit frame and presents the 14-bit result, extended to 16 bits, with a one-cycle valid strobe.

There are two operating styles, and the choice is latched for each sample. In normal mode the start line rests high and gets a short low pulse, so the converter stays awake. In power-saving mode the start line rests low. Each sample then begins with a short high pulse, which wakes the converter, and the falling edge that follows starts the conversion. Because the line is still low when the conversion finishes, the converter goes back to sleep.

Each data bit is captured on the same falling serial-clock edge that tells the converter to present the next bit. The elaboration step rejects any parameter set that breaks one of these limits:
- serial-clock high or low phase under 31.25 ns;
- falling-edge-to-capture spacing under 60 ns plus the input setup time;
- start pulse under 40 ns.

Top module: `adc_rd_ctrl`

## Requirements
- R1: During and right after reset, `adc_cnvst_n` is 1, `adc_sclk` is 0, and `sample_valid`, `frame_err` and `timeout_err` are 0.
- R2: A trigger starts a sample only while the controller is idle. A trigger is a `start_req` pulse or a periodic tick. A trigger that arrives while a sample is in progress is dropped and produces no extra sample or pulse.
- R3: In normal mode (`sleep_mode`=0), `adc_cnvst_n` is driven low for exactly `CNV_W` clock cycles. It then stays high through busy-wait and readout, and stays high while idle.
- R4: In power-saving mode (`sleep_mode`=1), `adc_cnvst_n` rests low. A trigger raises it for exactly `CNV_W` cycles, and it then stays low through busy-wait, readout and idle.
- R5: No serial-clock edge occurs while `adc_busy` is high. Readout starts only after a falling edge of `adc_busy` seen through a two-flop synchronizer.
- R6: A readout is exactly 16 serial-clock periods. Each high phase and each low phase lasts `SCK_HALF` system clocks. The first edge is a rising edge, and `adc_sclk` rests at 0 outside a readout.
- R7: Each bit is captured on the falling serial-clock edge, and the frame is assembled MSB first. Frame bits 15:14 are the leading bits, and bits 13:0 are the result, with bit 13 as its MSB.
- R8: With `bipolar`=1, `sample_data` is frame bits 13:0 sign-extended from bit 13. With `bipolar`=0, it is the same bits zero-extended.
- R9: `sample_valid` is a single-cycle pulse, issued together with the new `sample_data`.
- R10: `frame_err` pulses together with `sample_valid` when either leading frame bit is 1. The sample is still delivered.
- R11: If the synchronized busy line has not fallen within `TIMEOUT` cycles of the busy-wait starting, `timeout_err` pulses for one cycle. No sample is delivered, and the controller returns to idle with `adc_cnvst_n` at its rest level.
- R12: While `periodic_en` is 1, a trigger is generated every `PERIOD` cycles, so successive samples are spaced exactly `PERIOD` cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_req | input | 1 | One-cycle software conversion request |
| periodic_en | input | 1 | Enables the periodic trigger |
| sleep_mode | input | 1 | 1 selects power-saving operation |
| bipolar | input | 1 | 1 selects sign extension, 0 selects zero extension |
| adc_busy | input | 1 | Converter busy line (asynchronous) |
| adc_sdata | input | 1 | Converter serial data |
| adc_cnvst_n | output | 1 | Active-low conversion-start line |
| adc_sclk | output | 1 | Serial clock to converter |
| sample_data | output | FRAME_W | Extended sample |
| sample_valid | output | 1 | One-cycle strobe for a new sample |
| frame_err | output | 1 | Leading frame bits were not zero |
| timeout_err | output | 1 | Busy-wait timed out |

## Verification
The assertions check, on every cycle, the following properties:
- the serial-clock phase lengths and that the clock rests low outside readout;
- the exact start-pulse width and the start-line level held during busy-wait and readout in each mode;
- that the valid, framing-error and timeout strobes are single-cycle pulses;
- that the upper output bits agree with the latched extension mode.

Only the bench scenarios can show the rest. These are the bit order and the data values recovered from a modelled converter, that triggers arriving mid-sample are dropped, the timeout latency when busy never falls, and the exact spacing of periodic samples.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_WAIT  = 2'd2,
    ST_READ  = 2'd3
  } rd_state_e;
endpackage

// File: rtl/adc_rd_trigger.sv
module adc_rd_trigger #(
  parameter int PERIOD = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic periodic_en,
  input  logic start_req,
  output logic trig
);
  localparam int CW = $clog2(PERIOD + 1);

  logic [CW-1:0] cnt_q;
  logic          tick_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= 1'b0;
      if (!periodic_en) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(PERIOD - 1)) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign trig = start_req | tick_q;
endmodule

// File: rtl/adc_rd_busy_mon.sv
module adc_rd_busy_mon #(
  parameter int STAGES  = 2,
  parameter int TIMEOUT = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic busy_in,
  input  logic wait_en,
  output logic busy_fall,
  output logic timeout
);
  localparam int TW = $clog2(TIMEOUT + 1);

  logic [STAGES-1:0] sync_q;
  logic              prev_q;
  logic [TW-1:0]     cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], busy_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign busy_fall = prev_q & ~sync_q[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst || !wait_en) begin
      cnt_q <= '0;
    end else if (cnt_q != TW'(TIMEOUT - 1)) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign timeout = wait_en && (cnt_q == TW'(TIMEOUT - 1));
endmodule

// File: rtl/adc_rd_shifter.sv
module adc_rd_shifter #(
  parameter int SCK_HALF = 2,
  parameter int FRAME_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               sdata_in,
  output logic               sclk,
  output logic               done,
  output logic [FRAME_W-1:0] frame
);
  localparam int HW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;
  localparam int BW = $clog2(FRAME_W + 1);

  logic               active_q;
  logic               sclk_q;
  logic               done_q;
  logic [HW-1:0]      hcnt_q;
  logic [BW-1:0]      bits_q;
  logic [FRAME_W-1:0] shreg_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      hcnt_q   <= '0;
      bits_q   <= '0;
      shreg_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start && !active_q) begin
        active_q <= 1'b1;
        sclk_q   <= 1'b1;
        hcnt_q   <= '0;
        bits_q   <= '0;
      end else if (active_q) begin
        if (hcnt_q == HW'(SCK_HALF - 1)) begin
          hcnt_q <= '0;
          if (sclk_q) begin
            // falling edge: take the bit still held from the previous edge
            sclk_q  <= 1'b0;
            shreg_q <= {shreg_q[FRAME_W-2:0], sdata_in};
            if (bits_q == BW'(FRAME_W - 1)) begin
              active_q <= 1'b0;
              done_q   <= 1'b1;
            end else begin
              bits_q <= bits_q + 1'b1;
            end
          end else begin
            sclk_q <= 1'b1;
          end
        end else begin
          hcnt_q <= hcnt_q + 1'b1;
        end
      end
    end
  end

  assign sclk  = sclk_q;
  assign done  = done_q;
  assign frame = shreg_q;
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int SYS_CLK_PS  = 20000,
  parameter int SCK_HALF    = 2,
  parameter int SETUP_PS    = 5000,
  parameter int CNV_W       = 3,
  parameter int FRAME_W     = 16,
  parameter int RES_W       = 14,
  parameter int SYNC_STAGES = 2,
  parameter int TIMEOUT     = 5000,
  parameter int PERIOD      = 10000
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_req,
  input  logic               periodic_en,
  input  logic               sleep_mode,
  input  logic               bipolar,
  input  logic               adc_busy,
  input  logic               adc_sdata,
  output logic               adc_cnvst_n,
  output logic               adc_sclk,
  output logic [FRAME_W-1:0] sample_data,
  output logic               sample_valid,
  output logic               frame_err,
  output logic               timeout_err
);
  localparam int LEAD        = FRAME_W - RES_W;
  localparam int PW          = $clog2(CNV_W + 1);
  localparam int MIN_PHASE_PS = 31250;
  localparam int ACCESS_PS   = 60000;
  localparam int MIN_CNV_PS  = 40000;

  if (SCK_HALF * SYS_CLK_PS < MIN_PHASE_PS) begin : g_bad_phase
    $error("serial clock phase shorter than 31.25 ns");
  end
  if (2 * SCK_HALF * SYS_CLK_PS < ACCESS_PS + SETUP_PS) begin : g_bad_access
    $error("serial clock period shorter than data access plus setup");
  end
  if (CNV_W * SYS_CLK_PS < MIN_CNV_PS) begin : g_bad_cnv
    $error("conversion-start pulse shorter than 40 ns");
  end
  if (LEAD < 1 || SYNC_STAGES < 2) begin : g_bad_shape
    $error("frame must have leading bits and sync needs two stages");
  end

  rd_state_e          state_q;
  logic [PW-1:0]      pw_cnt_q;
  logic               sleep_q;
  logic               bip_q;
  logic               cnvst_n_q;
  logic [FRAME_W-1:0] sample_q;
  logic               valid_q;
  logic               ferr_q;
  logic               terr_q;

  logic               trig;
  logic               busy_fall;
  logic               tmo;
  logic               shift_start;
  logic               shift_done;
  logic [FRAME_W-1:0] frame_w;
  logic [FRAME_W-1:0] ext_w;
  logic               lead_bad;

  adc_rd_trigger #(.PERIOD(PERIOD)) trig_i (
    .clk         (clk),
    .rst         (rst),
    .periodic_en (periodic_en),
    .start_req   (start_req),
    .trig        (trig)
  );

  adc_rd_busy_mon #(.STAGES(SYNC_STAGES), .TIMEOUT(TIMEOUT)) busy_i (
    .clk       (clk),
    .rst       (rst),
    .busy_in   (adc_busy),
    .wait_en   (state_q == ST_WAIT),
    .busy_fall (busy_fall),
    .timeout   (tmo)
  );

  assign shift_start = (state_q == ST_WAIT) && busy_fall && !tmo;

  adc_rd_shifter #(.SCK_HALF(SCK_HALF), .FRAME_W(FRAME_W)) shift_i (
    .clk      (clk),
    .rst      (rst),
    .start    (shift_start),
    .sdata_in (adc_sdata),
    .sclk     (adc_sclk),
    .done     (shift_done),
    .frame    (frame_w)
  );

  // upper bits: copy of result MSB (signed) or zero (unsigned)
  for (genvar i = RES_W; i < FRAME_W; i++) begin : g_ext
    assign ext_w[i] = bip_q & frame_w[RES_W-1];
  end
  assign ext_w[RES_W-1:0] = frame_w[RES_W-1:0];
  assign lead_bad         = |frame_w[FRAME_W-1:RES_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_IDLE;
      pw_cnt_q  <= '0;
      sleep_q   <= 1'b0;
      bip_q     <= 1'b0;
      cnvst_n_q <= 1'b1;
      sample_q  <= '0;
      valid_q   <= 1'b0;
      ferr_q    <= 1'b0;
      terr_q    <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      ferr_q  <= 1'b0;
      terr_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          cnvst_n_q <= ~sleep_mode;
          pw_cnt_q  <= '0;
          if (trig) begin
            sleep_q   <= sleep_mode;
            bip_q     <= bipolar;
            cnvst_n_q <= sleep_mode;  // low pulse when awake, high pulse when asleep
            state_q   <= ST_PULSE;
          end
        end
        ST_PULSE: begin
          if (pw_cnt_q == PW'(CNV_W - 1)) begin
            cnvst_n_q <= ~sleep_q;
            state_q   <= ST_WAIT;
          end else begin
            pw_cnt_q <= pw_cnt_q + 1'b1;
          end
        end
        ST_WAIT: begin
          if (tmo) begin
            terr_q  <= 1'b1;
            state_q <= ST_IDLE;
          end else if (busy_fall) begin
            state_q <= ST_READ;
          end
        end
        ST_READ: begin
          if (shift_done) begin
            sample_q <= ext_w;
            valid_q  <= 1'b1;
            ferr_q   <= lead_bad;
            state_q  <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign adc_cnvst_n  = cnvst_n_q;
  assign sample_data  = sample_q;
  assign sample_valid = valid_q;
  assign frame_err    = ferr_q;
  assign timeout_err  = terr_q;
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk
  import adc_rd_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int CNV_W    = 3,
  parameter int FRAME_W  = 16,
  parameter int RES_W    = 14
) (
  input logic               clk,
  input logic               rst,
  input rd_state_e          state_q,
  input logic               sleep_q,
  input logic               bip_q,
  input logic               cnvst_n,
  input logic               sclk,
  input logic               sample_valid,
  input logic [FRAME_W-1:0] sample_data,
  input logic               frame_err,
  input logic               timeout_err
);
  logic        sclk_d, cn_d;
  logic [15:0] sclk_run, cn_run;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d   <= 1'b0;
      cn_d     <= 1'b1;
      sclk_run <= 16'd1;
      cn_run   <= 16'd1;
    end else begin
      sclk_d <= sclk;
      cn_d   <= cnvst_n;
      if (sclk != sclk_d) sclk_run <= 16'd1;
      else if (sclk_run != 16'hFFFF) sclk_run <= sclk_run + 16'd1;
      if (cnvst_n != cn_d) cn_run <= 16'd1;
      else if (cn_run != 16'hFFFF) cn_run <= cn_run + 16'd1;
    end
  end

  assert_sclk_rest_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_READ) |-> !sclk);

  assert_sclk_phase_R6: assert property (@(posedge clk) disable iff (rst)
    (sclk != sclk_d) |-> (sclk_run >= 16'(SCK_HALF)));

  assert_cnv_pulse_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && cnvst_n != cn_d) |-> (cn_run == 16'(CNV_W)));

  assert_cnv_level_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT || state_q == ST_READ) |-> (cnvst_n == !sleep_q));

  assert_valid_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  assert_ferr_with_valid_R10: assert property (@(posedge clk) disable iff (rst)
    frame_err |-> sample_valid);

  assert_extension_R8: assert property (@(posedge clk) disable iff (rst)
    sample_valid |-> (bip_q ? (sample_data[FRAME_W-1:RES_W-1] == '0 ||
                               sample_data[FRAME_W-1:RES_W-1] == '1)
                            : (sample_data[FRAME_W-1:RES_W] == '0)));

  assert_timeout_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    timeout_err |-> (!sample_valid && state_q == ST_IDLE));

  assert_timeout_once_R11: assert property (@(posedge clk) disable iff (rst)
    timeout_err |=> !timeout_err);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
  .SCK_HALF (SCK_HALF),
  .CNV_W    (CNV_W),
  .FRAME_W  (FRAME_W),
  .RES_W    (RES_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .state_q      (state_q),
  .sleep_q      (sleep_q),
  .bip_q        (bip_q),
  .cnvst_n      (adc_cnvst_n),
  .sclk         (adc_sclk),
  .sample_valid (sample_valid),
  .sample_data  (sample_data),
  .frame_err    (frame_err),
  .timeout_err  (timeout_err)
);

// File: tb/adc_rd_ctrl_tb_top.sv
module adc_rd_ctrl_tb_top;
  localparam int HALF = 2;
  localparam int CNVW = 3;
  localparam int TMO  = 400;
  localparam int PER  = 600;

  logic clk = 1'b0, rst = 1'b1;
  logic start_req = 1'b0, periodic_en = 1'b0, sleep_mode = 1'b0, bipolar = 1'b0;
  logic adc_busy = 1'b0, adc_sdata = 1'b0;
  logic adc_cnvst_n, adc_sclk, sample_valid, frame_err, timeout_err;
  logic [15:0] sample_data;

  always #10 clk = ~clk;

  adc_rd_ctrl #(.SCK_HALF(HALF), .CNV_W(CNVW), .TIMEOUT(TMO), .PERIOD(PER)) dut_i (
    .clk(clk), .rst(rst), .start_req(start_req), .periodic_en(periodic_en),
    .sleep_mode(sleep_mode), .bipolar(bipolar), .adc_busy(adc_busy),
    .adc_sdata(adc_sdata), .adc_cnvst_n(adc_cnvst_n), .adc_sclk(adc_sclk),
    .sample_data(sample_data), .sample_valid(sample_valid),
    .frame_err(frame_err), .timeout_err(timeout_err));

  int n_chk = 0, n_bad = 0, cyc = 0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // converter model
  logic [15:0] mdl_frame = 16'h0;
  bit mdl_hang = 1'b0;
  int mdl_idx = -1;

  always @(negedge adc_cnvst_n) begin
    if (!mdl_hang && !adc_busy) begin
      adc_busy = 1'b1;
      #2005;
      adc_busy  = 1'b0;
      adc_sdata = mdl_frame[15];
      mdl_idx   = 14;
    end
  end

  always @(negedge adc_sclk) begin
    #3;
    if (mdl_idx >= 0) begin
      adc_sdata = mdl_frame[mdl_idx];
      mdl_idx--;
    end else begin
      adc_sdata = 1'b0;
    end
  end

  // monitors
  int sclk_falls, sclk_hi, cn_low, cn_high, valid_cnt;
  bit sclk_in_busy;

  always @(posedge clk) cyc++;
  always @(negedge adc_sclk) sclk_falls++;
  always @(negedge clk) begin
    if (adc_busy && adc_sclk) sclk_in_busy = 1'b1;
    if (adc_sclk) sclk_hi++;
    if (!adc_cnvst_n) cn_low++; else cn_high++;
    if (sample_valid) valid_cnt++;
  end

  task automatic clear_mon();
    sclk_falls = 0; sclk_hi = 0; cn_low = 0; cn_high = 0; valid_cnt = 0;
    sclk_in_busy = 1'b0;
  endtask

  task automatic wait_valid(input int maxc, output bit seen);
    seen = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      if (sample_valid) begin seen = 1'b1; break; end
    end
  endtask

  task automatic pulse_start();
    start_req = 1'b1;
    @(negedge clk);
    start_req = 1'b0;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 cnvst_n in reset", adc_cnvst_n, 1);
    chk("R1 sclk in reset", adc_sclk, 0);
    chk("R1 strobes in reset", {sample_valid, frame_err, timeout_err}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 cnvst_n after reset", adc_cnvst_n, 1);
    chk("R1 strobes after reset", {sample_valid, frame_err, timeout_err, adc_sclk}, 0);
  endtask

  task automatic do_sample(input logic [15:0] frm, input logic bip, input logic slp);
    logic [15:0] exp_d;
    bit seen;
    exp_d = bip ? {{2{frm[13]}}, frm[13:0]} : {2'b00, frm[13:0]};
    mdl_frame = frm;
    if (slp != sleep_mode) begin
      sleep_mode = slp;
      repeat (150) @(negedge clk);
    end
    bipolar = bip;
    @(negedge clk);
    clear_mon();
    pulse_start();
    wait_valid(1000, seen);
    chk("R9 valid strobe seen", seen, 1);
    chk("R7 R8 sample data", sample_data, exp_d);
    chk("R10 frame error flag", frame_err, |frm[15:14]);
    chk("R6 falling sclk edges", sclk_falls, 16);
    chk("R6 sclk high cycles", sclk_hi, 16 * HALF);
    chk("R5 sclk while busy", sclk_in_busy, 0);
    if (slp) chk("R4 wake pulse width", cn_high, CNVW);
    else     chk("R3 start pulse width", cn_low, CNVW);
    @(negedge clk);
    chk("R9 strobe width", sample_valid, 0);
    chk("R6 sclk rest low", adc_sclk, 0);
    chk("R3 R4 rest level", adc_cnvst_n, !slp);
  endtask

  task automatic t_ignore();
    sleep_mode = 1'b0;
    mdl_frame  = 16'h0123;
    repeat (5) @(negedge clk);
    clear_mon();
    pulse_start();
    repeat (30) @(negedge clk);
    pulse_start();
    repeat (90) @(negedge clk);
    pulse_start();
    repeat (600) @(negedge clk);
    chk("R2 one sample for three requests", valid_cnt, 1);
    chk("R2 one start pulse", cn_low, CNVW);
  endtask

  task automatic t_timeout();
    bit seen = 1'b0;
    int el = 0;
    sleep_mode = 1'b0;
    mdl_hang   = 1'b1;
    repeat (5) @(negedge clk);
    clear_mon();
    pulse_start();
    for (int i = 0; i < 1000; i++) begin
      @(negedge clk);
      el++;
      if (timeout_err) begin seen = 1'b1; break; end
    end
    chk("R11 timeout raised", seen, 1);
    chk("R11 timeout latency in window", (el >= TMO && el <= TMO + 10), 1);
    @(negedge clk);
    chk("R11 timeout single pulse", timeout_err, 0);
    chk("R11 no sample on timeout", valid_cnt, 0);
    chk("R11 start line at rest", adc_cnvst_n, 1);
    mdl_hang = 1'b0;
  endtask

  task automatic t_periodic();
    bit seen;
    int t1, t2;
    sleep_mode = 1'b0;
    mdl_frame  = 16'h1555;
    bipolar    = 1'b0;
    repeat (5) @(negedge clk);
    clear_mon();
    periodic_en = 1'b1;
    wait_valid(2000, seen);
    t1 = cyc;
    chk("R12 first periodic sample", seen, 1);
    wait_valid(2000, seen);
    t2 = cyc;
    chk("R12 second periodic sample", seen, 1);
    chk("R12 sample spacing", t2 - t1, PER);
    chk("R12 periodic data", sample_data, 16'h1555);
    periodic_en = 1'b0;
    repeat (PER + 200) @(negedge clk);
    chk("R12 no samples once disabled", valid_cnt, 2);
  endtask

  initial begin
    t_reset();
    do_sample(16'h2ABC, 1'b1, 1'b0);
    do_sample(16'h2ABC, 1'b0, 1'b0);
    do_sample(16'h1FFF, 1'b1, 1'b0);
    do_sample(16'h8005, 1'b0, 1'b0);
    do_sample(16'h4001, 1'b1, 1'b0);
    do_sample(16'h3FFF, 1'b0, 1'b1);
    do_sample(16'h2000, 1'b1, 1'b1);
    t_ignore();
    t_timeout();
    t_periodic();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule